// File: doc/BRIEF.md
# Single-Word Memory Copy Engine

This block moves a run of bytes from one place in a byte-wide memory to another. Software controls it through one 32-bit control word that holds the source address, the destination address, the byte count and a start flag. Software writes the word with the start flag set. The engine then copies one byte per beat, lowest address first. When the copy is done, the engine clears the start flag. Software finds out that the copy has finished by reading the word until the flag reads 0.

The memory side has two channels. On the read channel, the engine sends a one-cycle request and then waits for a valid strobe that carries the data. On the write channel, the engine holds its request until the memory accepts it with a ready input. Each beat reads the current source byte, writes it to the current destination, and then steps both addresses up by one. While the start flag is set, a write to the control word is dropped, so the transfer settings cannot change in the middle of a copy.

Top module: `memcpy_dma`

## Requirements
- R1: While reset is asserted and right after it, the control word reads 0 and neither memory request is active.
- R2: Control word layout: bit 0 is the start flag, bit 1 is reserved and always reads 0, bits 12:2 hold the source address, bits 23:13 hold the destination address, and bits 31:24 hold the byte count. A write with bit 0 clear stores all fields and starts nothing.
- R3: After a copy of length L, destination bytes 0 to L-1 equal the source bytes as they were before the copy, and no other memory byte changes.
- R4: The start flag reads 1 from the write that sets it until the copy ends. When the memory answers each read one cycle after the request and accepts each write at once, the flag clears exactly 1+3·L cycles after that write.
- R5: A byte count of 0 clears the start flag one cycle after the write and issues no memory request.
- R6: A control-word write that arrives while the start flag is set is ignored. The fields keep their values, and the running copy uses the original settings.
- R7: Each read request lasts one cycle and is issued once per byte. Each write request, with its address and data, stays stable until ready is seen, and exactly L writes are accepted.
- R8: Read addresses go up from the source address by one per beat. Write addresses go up from the destination address by one per beat.
- R9: A read request and a write request are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Control word write strobe |
| reg_wdata_i | input | 32 | Control word write data |
| reg_rdata_o | output | 32 | Control word read data |
| mem_rd_o | output | 1 | Read request, one-cycle pulse |
| mem_rd_addr_o | output | 11 | Read byte address |
| mem_rd_valid_i | input | 1 | Read data valid |
| mem_rd_data_i | input | 8 | Read data |
| mem_wr_o | output | 1 | Write request, held until ready |
| mem_wr_addr_o | output | 11 | Write byte address |
| mem_wr_data_o | output | 8 | Write data |
| mem_wr_ready_i | input | 1 | Write accepted |

## Verification
A write to the control word takes effect at the clock edge where it is sampled, so the start flag is checked on the falling edge that follows that edge. When the memory replies promptly, the bench counts falling edges from that point and expects the flag to clear at count 1+3·L: one cycle to launch the copy, then a request cycle, a wait cycle and a write cycle for each byte. It expects a zero-length copy to clear the flag at count 1. When write-ready is throttled, the bench does not check the cycle count. It checks only the data and the number of accesses, and the assertions check that each write request is held stable while it waits.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int ADDR_W    = 11;
  localparam int LEN_W     = 8;
  localparam int DATA_W    = 8;
  localparam int START_BIT = 0;
  localparam int SRC_LSB   = 2;
  localparam int DST_LSB   = SRC_LSB + ADDR_W;
  localparam int LEN_LSB   = DST_LSB + ADDR_W;
  localparam int REG_W     = LEN_LSB + LEN_W;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RD   = 2'd1,
    SEQ_WAIT = 2'd2,
    SEQ_WR   = 2'd3
  } seq_state_e;

  // field order equals bit order of the control word above bit 1
  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] src;
  } xfer_cfg_t;
endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
  import dma_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             done_i,
  output logic             start_o,
  output xfer_cfg_t        cfg_o,
  output logic [REG_W-1:0] rdata_o
);
  xfer_cfg_t cfg_q;
  logic      start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      start_q <= 1'b0;
    end else if (start_q) begin
      if (done_i) start_q <= 1'b0;
    end else if (we_i) begin
      cfg_q   <= wdata_i[REG_W-1:SRC_LSB];
      start_q <= wdata_i[START_BIT];
    end
  end

  assign start_o = start_q;
  assign cfg_o   = cfg_q;
  assign rdata_o = {cfg_q, 1'b0, start_q};

  assert_busy_fields_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> $stable(cfg_q));
  assert_done_when_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> start_q);
  assert_done_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && done_i) |=> !start_q);
endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  xfer_cfg_t         cfg_i,
  output logic              done_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic              mem_rd_valid_i,
  input  logic [DATA_W-1:0] mem_rd_data_i,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [DATA_W-1:0] mem_wr_data_o,
  input  logic              mem_wr_ready_i
);
  seq_state_e        state_q;
  logic [ADDR_W-1:0] src_q, dst_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [DATA_W-1:0] data_q;
  logic              zero_len, last_beat;

  assign zero_len  = (state_q == SEQ_IDLE) && start_i && (cfg_i.len == '0);
  assign last_beat = (state_q == SEQ_WR) && mem_wr_ready_i && (cnt_q == LEN_W'(1));
  assign done_o    = zero_len || last_beat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start_i && cfg_i.len != '0) begin
          src_q   <= cfg_i.src;
          dst_q   <= cfg_i.dst;
          cnt_q   <= cfg_i.len;
          state_q <= SEQ_RD;
        end
        SEQ_RD:   state_q <= SEQ_WAIT;
        SEQ_WAIT: if (mem_rd_valid_i) begin
          data_q  <= mem_rd_data_i;
          state_q <= SEQ_WR;
        end
        SEQ_WR: if (mem_wr_ready_i) begin
          src_q   <= src_q + ADDR_W'(1);
          dst_q   <= dst_q + ADDR_W'(1);
          cnt_q   <= cnt_q - LEN_W'(1);
          state_q <= last_beat ? SEQ_IDLE : SEQ_RD;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign mem_rd_o      = (state_q == SEQ_RD);
  assign mem_rd_addr_o = src_q;
  assign mem_wr_o      = (state_q == SEQ_WR);
  assign mem_wr_addr_o = dst_q;
  assign mem_wr_data_o = data_q;

  assert_rd_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);
  assert_wr_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && !mem_wr_ready_i) |=>
      (mem_wr_o && $stable(mem_wr_addr_o) && $stable(mem_wr_data_o)));
  assert_no_overlap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  assert_addr_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && mem_wr_ready_i && !done_o) |=>
      (mem_rd_o && mem_rd_addr_o == ADDR_W'($past(mem_rd_addr_o) + ADDR_W'(1))));
  assert_zero_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_len |=> (state_q == SEQ_IDLE && !mem_rd_o && !mem_wr_o));
endmodule

// File: rtl/memcpy_dma.sv
module memcpy_dma
  import dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              mem_rd_o,
  output logic [ADDR_W-1:0] mem_rd_addr_o,
  input  logic              mem_rd_valid_i,
  input  logic [DATA_W-1:0] mem_rd_data_i,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] mem_wr_addr_o,
  output logic [DATA_W-1:0] mem_wr_data_o,
  input  logic              mem_wr_ready_i
);
  logic      start, done;
  xfer_cfg_t cfg;

  dma_ctrl_reg i_ctrl_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .wdata_i (reg_wdata_i),
    .done_i  (done),
    .start_o (start),
    .cfg_o   (cfg),
    .rdata_o (reg_rdata_o)
  );

  dma_seq i_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .start_i        (start),
    .cfg_i          (cfg),
    .done_o         (done),
    .mem_rd_o       (mem_rd_o),
    .mem_rd_addr_o  (mem_rd_addr_o),
    .mem_rd_valid_i (mem_rd_valid_i),
    .mem_rd_data_i  (mem_rd_data_i),
    .mem_wr_o       (mem_wr_o),
    .mem_wr_addr_o  (mem_wr_addr_o),
    .mem_wr_data_o  (mem_wr_data_o),
    .mem_wr_ready_i (mem_wr_ready_i)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (reg_rdata_o == '0 && !mem_rd_o && !mem_wr_o));
endmodule

// File: tb/test_memcpy_dma.sv
module test_memcpy_dma;
  localparam int MEM_N = 2048;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        mem_rd_o, mem_wr_o;
  logic [10:0] mem_rd_addr_o, mem_wr_addr_o;
  logic        mem_rd_valid_i = 1'b0;
  logic [7:0]  mem_rd_data_i = '0;
  logic [7:0]  mem_wr_data_o;
  logic        mem_wr_ready_i;

  logic [7:0] mem [MEM_N];
  logic [7:0] ref_mem [MEM_N];
  logic       stall = 1'b0, tgl = 1'b0, finished = 1'b0;
  int total = 0, bad = 0;
  int rd_cnt = 0, wr_cnt = 0, order_err = 0;
  logic [10:0] mon_src = '0, mon_dst = '0;

  always #2.5 clk_i = ~clk_i;

  memcpy_dma i_memcpy_dma (.*);

  assign mem_wr_ready_i = stall ? tgl : 1'b1;

  always @(posedge clk_i) begin
    tgl            <= ~tgl;
    mem_rd_valid_i <= mem_rd_o;
    mem_rd_data_i  <= mem[mem_rd_addr_o];
    if (mem_wr_o && mem_wr_ready_i) mem[mem_wr_addr_o] <= mem_wr_data_o;
  end

  // R8 address order monitor, R7 access counts
  always @(negedge clk_i) begin
    if (mem_rd_o) begin
      if (mem_rd_addr_o != mon_src) order_err++;
      mon_src <= mon_src + 11'd1;
      rd_cnt++;
    end
    if (mem_wr_o && mem_wr_ready_i) begin
      if (mem_wr_addr_o != mon_dst) order_err++;
      mon_dst <= mon_dst + 11'd1;
      wr_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  function automatic int mem_diff();
    int n = 0;
    for (int i = 0; i < MEM_N; i++) if (mem[i] !== ref_mem[i]) n++;
    return n;
  endfunction

  task automatic run_copy(input logic [10:0] src, input logic [10:0] dst,
                          input logic [7:0] len, input bit timed);
    int c = 0;
    for (int i = 0; i < int'(len); i++) ref_mem[11'(dst + 11'(i))] = ref_mem[11'(src + 11'(i))];
    rd_cnt = 0; wr_cnt = 0; order_err = 0; mon_src = src; mon_dst = dst;
    reg_write({len, dst, src, 2'b01});
    check(reg_rdata_o[0] == 1'b1, "R4", reg_rdata_o[0], 1);
    while (reg_rdata_o[0] && c < 4000) begin
      @(negedge clk_i); c++;
    end
    if (timed) check(c == 1 + 3 * int'(len), "R4", c, 1 + 3 * int'(len));
    if (len == 0) check(rd_cnt == 0 && wr_cnt == 0 && c == 1, "R5", rd_cnt + wr_cnt, 0);
    check(mem_diff() == 0, "R3", mem_diff(), 0);
    check(rd_cnt == int'(len) && wr_cnt == int'(len), "R7", wr_cnt, len);
    check(order_err == 0, "R8", order_err, 0);
    check(reg_rdata_o == {len, dst, src, 2'b00}, "R2", reg_rdata_o, {len, dst, src, 2'b00});
  endtask

  // {src, dst, len}
  localparam logic [29:0] VEC [5] = '{
    {11'h030, 11'h300, 8'd128},
    {11'h000, 11'h100, 8'd1},
    {11'h7F0, 11'h400, 8'd16},
    {11'h123, 11'h456, 8'd255},
    {11'h200, 11'h700, 8'd2}
  };

  initial begin
    for (int i = 0; i < MEM_N; i++) begin
      mem[i] = 8'(i * 37 + 11);
      ref_mem[i] = 8'(i * 37 + 11);
    end
    repeat (3) @(negedge clk_i);
    check(reg_rdata_o == 32'h0 && !mem_rd_o && !mem_wr_o, "R1", reg_rdata_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(reg_rdata_o == 32'h0 && !mem_rd_o && !mem_wr_o, "R1", reg_rdata_o, 0);

    // R2 layout, reserved bit, no start
    reg_write(32'hFFFF_FFFE);
    check(reg_rdata_o == 32'hFFFF_FFFC, "R2", reg_rdata_o, 32'hFFFF_FFFC);
    reg_write(32'h5A5A_5A5A);
    repeat (3) @(negedge clk_i);
    check(reg_rdata_o == 32'h5A5A_5A58 && rd_cnt == 0, "R2", reg_rdata_o, 32'h5A5A_5A58);

    for (int v = 0; v < 5; v++)
      run_copy(VEC[v][29:19], VEC[v][18:8], VEC[v][7:0], 1'b1);

    // R5 zero length
    run_copy(11'h050, 11'h060, 8'd0, 1'b1);

    // R6 write while busy
    begin
      logic [31:0] cfg_w = {8'd8, 11'h600, 11'h010, 2'b01};
      int c = 0;
      for (int i = 0; i < 8; i++) ref_mem[11'h600 + i] = ref_mem[11'h010 + i];
      rd_cnt = 0; wr_cnt = 0; order_err = 0; mon_src = 11'h010; mon_dst = 11'h600;
      reg_write(cfg_w);
      reg_write(32'hFFFF_FFFF);
      check(reg_rdata_o == cfg_w, "R6", reg_rdata_o, cfg_w);
      while (reg_rdata_o[0] && c < 4000) begin
        @(negedge clk_i); c++;
      end
      check(reg_rdata_o == (cfg_w & ~32'h1), "R6", reg_rdata_o, cfg_w & ~32'h1);
      check(mem_diff() == 0 && wr_cnt == 8, "R6", mem_diff(), 0);
    end

    // R7 throttled write ready
    stall = 1'b1;
    run_copy(11'h080, 11'h6A0, 8'd20, 1'b0);
    stall = 1'b0;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule